// File: doc/BRIEF.md
# Voted Configuration Word with Spare-Channel Steering

This block keeps the 16-bit configuration word of a four-channel optical link chip. It also turns that word into the settings the chip's datapaths use. A word reaches the block by one of two routes. The first route is three redundant command decoders: their words are combined bit by bit in a two-of-three vote. The second route is a slow serial test port. Its clock and data pins fill a shadow register, and a load strobe commits the shadow contents. A select input decides which of the two routes is allowed to change the active word.

Each committed word is decoded by its two top bits, which form the operation field.
- A routing word sets the spare-steering selects for both link directions. On the receive side, each of the three regular outputs can take the spare input in place of its own. On the transmit side, the spare output can carry its own input or the input of any one of the three other channels.
- A current word writes one transmit channel's 8-bit drive setting and leaves the other three as they are.
- The two remaining operation codes only update the stored word.

After reset every drive setting holds a nominal value. If the command path never delivers a valid vote, that value stays in place.

A mismatch output goes high whenever the three decoder words are not all equal. A single upset can therefore be seen even when the vote hides it.

Top module: `cfgword_vote_steer`

## Requirements
- R1: While reset is asserted, and after it is released with no update applied, `cfg_word` is 16'h0000, `rx_use_spare` is 0, `tx_spare_src` is 0 and every 8-bit field of `tx_current` is 160 (8'hA0).
- R2: With `tp_sel` low and at least two bits of `cmd_valid` high in a clock cycle, the bitwise two-of-three majority of `cmd_word_a/b/c` becomes `cfg_word` at that clock edge and is decoded as in R5 to R7.
- R3: With `tp_sel` low and fewer than two bits of `cmd_valid` high, no output other than `cfg_mismatch` changes.
- R4: `cfg_mismatch` is combinational. It is 1 exactly when the three command words are not all identical, whatever the valid strobes are.
- R5: An applied word with bits [15:14] = 2'b00 is a routing word. Bits [2:0] go to `rx_use_spare`, where bit i = 1 means receive output i takes the spare input. Bits [4:3] go to `tx_spare_src`, where 0 means the spare carries its own input and k = 1..3 means it carries the input of channel k-1. The drive currents are unchanged.
- R6: An applied word with bits [15:14] = 2'b01 writes bits [7:0] into the current field of the channel named by bits [9:8]. Field i is `tx_current[8i+7:8i]`. The other channels and the routing are unchanged.
- R7: An applied word with bits [15:14] = 2'b10 or 2'b11 updates `cfg_word` only. Routing and currents keep their values.
- R8: Each rising edge of `tp_clk` shifts `tp_dat` into a 16-bit shadow register, MSB first. The edge is sampled through a two-stage synchronizer. With `tp_sel` high, a one-cycle `tp_load` commits the shadow to `cfg_word` at that clock edge, decoded as in R5 to R7.
- R9: While `tp_sel` is high, command-path words are ignored regardless of `cmd_valid`.
- R10: While `tp_sel` is low, `tp_load` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_word_a | input | 16 | Word from command decoder A |
| cmd_word_b | input | 16 | Word from command decoder B |
| cmd_word_c | input | 16 | Word from command decoder C |
| cmd_valid | input | 3 | Per-decoder word strobes (bit 0 = A, 1 = B, 2 = C) |
| tp_sel | input | 1 | 1 selects the serial test port as the update source |
| tp_clk | input | 1 | Serial test-port shift clock, sampled by `clk` |
| tp_dat | input | 1 | Serial test-port data, MSB first |
| tp_load | input | 1 | One-cycle strobe committing the shadow register |
| cfg_word | output | 16 | Active configuration word |
| rx_use_spare | output | 3 | Per receive output: 1 = take the spare input |
| tx_spare_src | output | 2 | Transmit spare source: 0 = own, k = channel k-1 |
| tx_current | output | 32 | Four 8-bit drive settings, channel i at bits [8i+7:8i] |
| cfg_mismatch | output | 1 | Command words are not all identical |

## Verification
The bench presents single-bit and two-bit upsets spread over different decoders. A voter that picked one decoder instead of voting per bit would then commit a corrupted word. A voter that flagged only in valid cycles would miss the mismatch.

Strobe patterns with exactly one and exactly two valids probe the threshold. A design with an off-by-one count would either drop legal updates or accept a lone decoder.

Serial words are shifted in and committed with the source select in both positions. This exposes a reversed bit order, a load accepted while the port is deselected, and command updates that leak through while the test port owns the word.

Current writes to the first and last channels, plus reserved operation codes, catch a wrong channel index and decoding that touches fields it should leave alone.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
  typedef enum logic [1:0] {
    OP_ROUTE   = 2'b00,
    OP_CURRENT = 2'b01,
    OP_RSV_A   = 2'b10,
    OP_RSV_B   = 2'b11
  } cfg_op_e;
endpackage

// File: rtl/cfgw_rst_sync.sv
module cfgw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cfgw_voter.sv
module cfgw_voter #(
  parameter int W = 16
) (
  input  logic [W-1:0] word_a,
  input  logic [W-1:0] word_b,
  input  logic [W-1:0] word_c,
  input  logic [2:0]   valid,
  output logic [W-1:0] voted,
  output logic         vote_ok,
  output logic         mismatch
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign voted[i] = (word_a[i] & word_b[i]) | (word_a[i] & word_c[i]) |
                      (word_b[i] & word_c[i]);
  end

  assign vote_ok  = (valid[0] & valid[1]) | (valid[0] & valid[2]) |
                    (valid[1] & valid[2]);
  assign mismatch = (word_a != word_b) | (word_b != word_c);
endmodule

// File: rtl/cfgw_tport.sv
module cfgw_tport #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tp_clk,
  input  logic         tp_dat,
  output logic [W-1:0] shadow
);
  logic [STAGES-1:0] clk_sync_q, clk_sync_d;
  logic [STAGES-1:0] dat_sync_q, dat_sync_d;
  logic              clk_prev_q, clk_prev_d;
  logic [W-1:0]      shadow_q, shadow_d;
  logic              shift_en;

  always_comb begin
    clk_sync_d = {clk_sync_q[STAGES-2:0], tp_clk};
    dat_sync_d = {dat_sync_q[STAGES-2:0], tp_dat};
    clk_prev_d = clk_sync_q[STAGES-1];
    shift_en   = clk_sync_q[STAGES-1] & ~clk_prev_q;
    shadow_d   = shift_en ? {shadow_q[W-2:0], dat_sync_q[STAGES-1]} : shadow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sync_q <= '0;
      dat_sync_q <= '0;
      clk_prev_q <= 1'b0;
      shadow_q   <= '0;
    end else begin
      clk_sync_q <= clk_sync_d;
      dat_sync_q <= dat_sync_d;
      clk_prev_q <= clk_prev_d;
      shadow_q   <= shadow_d;
    end
  end

  assign shadow = shadow_q;
endmodule

// File: rtl/cfgw_apply.sv
module cfgw_apply
  import cfgw_pkg::*;
#(
  parameter int          W        = 16,
  parameter int          NCH      = 4,
  parameter int          CW       = 8,
  parameter logic [CW-1:0] DEF_CUR  = 8'd160,
  parameter logic [W-1:0]  DEF_WORD = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              apply,
  input  logic [W-1:0]      word_in,
  output logic [W-1:0]      cfg_word,
  output logic [NCH-2:0]    rx_use_spare,
  output logic [$clog2(NCH)-1:0] tx_spare_src,
  output logic [NCH*CW-1:0] tx_current
);
  localparam int RXW   = NCH - 1;
  localparam int SW    = $clog2(NCH);
  localparam int TX_LO = RXW;
  localparam int CH_LO = CW;

  cfg_op_e         op;
  logic [W-1:0]    word_q, word_d;
  logic [RXW-1:0]  rx_q, rx_d;
  logic [SW-1:0]   tx_q, tx_d;
  logic            route_en, cur_en;

  always_comb begin
    op       = cfg_op_e'(word_in[W-1 -: 2]);
    route_en = apply & (op == OP_ROUTE);
    cur_en   = apply & (op == OP_CURRENT);
    word_d   = apply    ? word_in                : word_q;
    rx_d     = route_en ? word_in[RXW-1:0]        : rx_q;
    tx_d     = route_en ? word_in[TX_LO +: SW]    : tx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= DEF_WORD;
      rx_q   <= '0;
      tx_q   <= '0;
    end else begin
      word_q <= word_d;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_cur
    logic [CW-1:0] cur_q, cur_d;
    logic          hit;

    always_comb begin
      hit   = cur_en & (word_in[CH_LO +: SW] == SW'(ch));
      cur_d = hit ? word_in[CW-1:0] : cur_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_q <= DEF_CUR;
      else        cur_q <= cur_d;
    end

    assign tx_current[ch*CW +: CW] = cur_q;
  end

  assign cfg_word     = word_q;
  assign rx_use_spare = rx_q;
  assign tx_spare_src = tx_q;
endmodule

// File: rtl/cfgword_vote_steer.sv
module cfgword_vote_steer #(
  parameter int            W        = 16,
  parameter int            NCH      = 4,
  parameter int            CW       = 8,
  parameter int            STAGES   = 2,
  parameter logic [CW-1:0] DEF_CUR  = 8'd160,
  parameter logic [W-1:0]  DEF_WORD = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      cmd_word_a,
  input  logic [W-1:0]      cmd_word_b,
  input  logic [W-1:0]      cmd_word_c,
  input  logic [2:0]        cmd_valid,
  input  logic              tp_sel,
  input  logic              tp_clk,
  input  logic              tp_dat,
  input  logic              tp_load,
  output logic [W-1:0]      cfg_word,
  output logic [NCH-2:0]    rx_use_spare,
  output logic [$clog2(NCH)-1:0] tx_spare_src,
  output logic [NCH*CW-1:0] tx_current,
  output logic              cfg_mismatch
);
  logic         rst_int_n;
  logic [W-1:0] voted;
  logic         vote_ok;
  logic [W-1:0] shadow;
  logic         apply;
  logic [W-1:0] word_sel;

  cfgw_rst_sync #(.STAGES(STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  cfgw_voter #(.W(W)) u_vote (
    .word_a   (cmd_word_a),
    .word_b   (cmd_word_b),
    .word_c   (cmd_word_c),
    .valid    (cmd_valid),
    .voted    (voted),
    .vote_ok  (vote_ok),
    .mismatch (cfg_mismatch)
  );

  cfgw_tport #(.W(W), .STAGES(STAGES)) u_tp (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tp_clk (tp_clk),
    .tp_dat (tp_dat),
    .shadow (shadow)
  );

  always_comb begin
    apply    = tp_sel ? tp_load : vote_ok;
    word_sel = tp_sel ? shadow  : voted;
  end

  cfgw_apply #(
    .W(W), .NCH(NCH), .CW(CW), .DEF_CUR(DEF_CUR), .DEF_WORD(DEF_WORD)
  ) u_apply (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .apply        (apply),
    .word_in      (word_sel),
    .cfg_word     (cfg_word),
    .rx_use_spare (rx_use_spare),
    .tx_spare_src (tx_spare_src),
    .tx_current   (tx_current)
  );
endmodule

// File: rtl/cfgw_checker.sv
module cfgw_checker #(
  parameter int W   = 16,
  parameter int NCH = 4,
  parameter int CW  = 8
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic [W-1:0]      cmd_word_a,
  input logic [W-1:0]      cmd_word_b,
  input logic [W-1:0]      cmd_word_c,
  input logic [2:0]        cmd_valid,
  input logic              tp_sel,
  input logic              tp_load,
  input logic [W-1:0]      cfg_word,
  input logic [NCH-2:0]    rx_use_spare,
  input logic [$clog2(NCH)-1:0] tx_spare_src,
  input logic [NCH*CW-1:0] tx_current,
  input logic              cfg_mismatch
);
  assert_hold_few_valid_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!tp_sel && $countones(cmd_valid) < 2) |=>
      ($stable(cfg_word) && $stable(rx_use_spare) && $stable(tx_spare_src) && $stable(tx_current)));

  assert_unanimous_apply_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!tp_sel && $countones(cmd_valid) >= 2 && cmd_word_a == cmd_word_b && cmd_word_b == cmd_word_c)
      |=> (cfg_word == $past(cmd_word_a)));

  assert_mismatch_clear_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_word_a == cmd_word_b && cmd_word_b == cmd_word_c) |-> !cfg_mismatch);

  assert_mismatch_set_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_word_a != cmd_word_c) |-> cfg_mismatch);

  assert_port_owns_word_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tp_sel && !tp_load) |=> ($stable(cfg_word) && $stable(tx_current)));
endmodule

bind cfgword_vote_steer cfgw_checker #(.W(W), .NCH(NCH), .CW(CW)) u_chk (
  .clk          (clk),
  .rst_int_n    (rst_int_n),
  .cmd_word_a   (cmd_word_a),
  .cmd_word_b   (cmd_word_b),
  .cmd_word_c   (cmd_word_c),
  .cmd_valid    (cmd_valid),
  .tp_sel       (tp_sel),
  .tp_load      (tp_load),
  .cfg_word     (cfg_word),
  .rx_use_spare (rx_use_spare),
  .tx_spare_src (tx_spare_src),
  .tx_current   (tx_current),
  .cfg_mismatch (cfg_mismatch)
);

// File: tb/tb_cfgword_vote_steer.sv
module tb_cfgword_vote_steer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cmd_word_a, cmd_word_b, cmd_word_c;
  logic [2:0]  cmd_valid;
  logic        tp_sel, tp_clk, tp_dat, tp_load;
  logic [15:0] cfg_word;
  logic [2:0]  rx_use_spare;
  logic [1:0]  tx_spare_src;
  logic [31:0] tx_current;
  logic        cfg_mismatch;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [15:0] exp_word;
  logic [2:0]  exp_rx;
  logic [1:0]  exp_tx;
  logic [7:0]  exp_cur [4];

  always #2 clk = ~clk;

  cfgword_vote_steer dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_word_a(cmd_word_a), .cmd_word_b(cmd_word_b), .cmd_word_c(cmd_word_c),
    .cmd_valid(cmd_valid), .tp_sel(tp_sel), .tp_clk(tp_clk), .tp_dat(tp_dat),
    .tp_load(tp_load), .cfg_word(cfg_word), .rx_use_spare(rx_use_spare),
    .tx_spare_src(tx_spare_src), .tx_current(tx_current), .cfg_mismatch(cfg_mismatch)
  );

  function automatic logic [15:0] maj3(logic [15:0] a, logic [15:0] b, logic [15:0] c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk({req, " word"}, 32'(cfg_word), 32'(exp_word));
    chk({req, " rx"}, 32'(rx_use_spare), 32'(exp_rx));
    chk({req, " tx"}, 32'(tx_spare_src), 32'(exp_tx));
    for (int i = 0; i < 4; i++) chk({req, " cur"}, 32'(tx_current[i*8 +: 8]), 32'(exp_cur[i]));
  endtask

  task automatic model_apply(logic [15:0] w);
    exp_word = w;
    case (w[15:14])
      2'b00: begin exp_rx = w[2:0]; exp_tx = w[4:3]; end
      2'b01: exp_cur[w[9:8]] = w[7:0];
      default: ;
    endcase
  endtask

  task automatic cmd_cycle(string req, logic [15:0] a, logic [15:0] b, logic [15:0] c, logic [2:0] v);
    @(negedge clk);
    cmd_word_a = a; cmd_word_b = b; cmd_word_c = c; cmd_valid = v;
    #1;
    chk("R4 mismatch", 32'(cfg_mismatch), 32'(!(a == b && b == c)));
    @(negedge clk);
    cmd_valid = 3'b000;
    if (!tp_sel && $countones(v) >= 2) model_apply(maj3(a, b, c));
    chk_all(req);
  endtask

  task automatic tp_shift(logic [15:0] w);
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk); tp_clk = 1'b0; tp_dat = w[i];
      repeat (3) @(negedge clk);
      tp_clk = 1'b1;
      repeat (3) @(negedge clk);
    end
    tp_clk = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic tp_commit(string req, logic [15:0] w);
    @(negedge clk); tp_load = 1'b1;
    @(negedge clk); tp_load = 1'b0;
    if (tp_sel) model_apply(w);
    chk_all(req);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    cmd_word_a = '0; cmd_word_b = '0; cmd_word_c = '0; cmd_valid = '0;
    tp_sel = 1'b0; tp_clk = 1'b0; tp_dat = 1'b0; tp_load = 1'b0;
    exp_word = 16'h0000; exp_rx = '0; exp_tx = '0;
    for (int i = 0; i < 4; i++) exp_cur[i] = 8'd160;

    repeat (4) @(negedge clk);
    chk_all("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_all("R1 after release");

    // R2 R5: unanimous routing word
    cmd_cycle("R5 route", 16'h001D, 16'h001D, 16'h001D, 3'b111);
    // R2 R4: single upset on decoder C
    cmd_cycle("R2 single upset", 16'h0012, 16'h0012, 16'h0812, 3'b111);
    // R2 R6: upsets on different decoders, current write ch2
    cmd_cycle("R6 cur ch2", 16'h4277, 16'h4276, 16'h4A77, 3'b111);
    // R3: one valid only
    cmd_cycle("R3 lone valid", 16'h4355, 16'h4355, 16'h4355, 3'b001);
    // R4 with no valids, R3
    cmd_cycle("R3 no valid", 16'h0001, 16'h0002, 16'h0004, 3'b000);
    // R2: two valids suffice, current write ch3
    cmd_cycle("R2 two valids", 16'h4355, 16'h4355, 16'h4355, 3'b110);
    cmd_cycle("R6 cur ch0", 16'h4011, 16'h4011, 16'h4011, 3'b011);
    // R7: reserved opcodes
    cmd_cycle("R7 reserved 10", 16'h8FFF, 16'h8FFF, 16'h8FFF, 3'b111);
    cmd_cycle("R7 reserved 11", 16'hC31B, 16'hC31B, 16'hC31B, 3'b101);

    // R9: test port selected, command ignored
    tp_sel = 1'b1;
    cmd_cycle("R9 cmd ignored", 16'h40AA, 16'h40AA, 16'h40AA, 3'b111);
    // R8: serial load of a current word then a routing word
    tp_shift(16'h4033);
    chk_all("R8 no change before load");
    tp_commit("R8 tp cur ch0", 16'h4033);
    tp_shift(16'h0009);
    tp_commit("R8 tp route", 16'h0009);
    tp_shift(16'h43C4);
    tp_commit("R8 tp cur ch3", 16'h43C4);

    // R10: load ignored when port not selected
    tp_sel = 1'b0;
    tp_shift(16'h41EE);
    tp_commit("R10 load ignored", 16'h41EE);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [15:0] base, a, b, c, flip;
      logic [2:0]  v;
      int sel;
      base = 16'($urandom);
      flip = 16'($urandom) & 16'($urandom);
      a = base; b = base; c = base;
      sel = int'($urandom_range(0, 4));
      case (sel)
        1: a = base ^ flip;
        2: b = base ^ flip;
        3: c = base ^ flip;
        4: begin a = base ^ (flip & 16'h00FF); c = base ^ (flip & 16'hFF00); end
        default: ;
      endcase
      v = 3'($urandom_range(0, 7));
      tp_sel = ($urandom_range(0, 7) == 0);
      cmd_cycle(tp_sel ? "R9 random" : "R2 random", a, b, c, v);
    end
    tp_sel = 1'b0;

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule